// File: doc/BRIEF.md
# Hysteretic Gain-Range Controller

This block picks which of four programmable-gain states a detector readout runs in. Rather than reacting to any single sample, it collects a fixed power-of-two window of sample magnitudes together with their saturation flags. From the window mean and the count of saturated samples it forms a request to move one state up or one state down. The request is applied only at a row boundary. After every switch the decision is frozen for a programmable number of rows, so the range cannot hunt across a boundary.

Two separate levels give the hysteresis. A window mean above the upper level asks for less gain. A mean below the lower level asks for more gain. A mean between the two leaves the state alone. Too many saturated samples in a window always ask for less gain. While an external overload-recovery signal is high, pending requests are discarded and the state is driven to the conservative (lowest-gain) state. Each row is tagged with the gain state it was read in, so downstream correction can pick its per-state offset and gain tables.

Top module: `gain_range_ctrl`

## Requirements
- R1: After reset, the gain index is the safe state 0, and the switch pulse, the row tag and the row-tag valid are all 0.
- R2: A request is formed only when a full window of 2^WIN_LOG2 valid samples has been collected. A partial window has no effect. The window mean is the sum of the magnitudes shifted right by WIN_LOG2, so the remainder is dropped.
- R3: Gain index 0 is the lowest gain and index 3 is the highest. A window mean strictly above `lvl_hi` requests one step down in index. A mean strictly below `lvl_lo` requests one step up. A mean between the two levels, or equal to either, requests no change.
- R4: If the window's count of saturated samples is strictly greater than `sat_limit`, the window requests one step down in index, whatever its mean.
- R5: The index changes by exactly one state per switch. A down request at index 0, or an up request at index 3, is consumed with no change and no pulse.
- R6: The gain index changes only on the clock edge that samples `row_stb` high. `gain_switch` is high for exactly the one cycle after that edge, and only when the index changed.
- R7: A switch loads a hold-off counter with `holdoff_rows`. Each later row strobe decrements it. While it is nonzero, a row strobe applies no request, and the pending request is kept for the first row strobe after the counter reaches zero.
- R8: While `recov_busy` is high, every pending request and every completed window is discarded. Each row strobe forces the index to 0, ignoring hold-off. A forced change pulses `gain_switch` and reloads the hold-off counter.
- R9: On the cycle after each row strobe, `row_tag_vld` is high for one cycle and `row_tag` holds the gain index in effect for the row now starting.
- R10: Each completed window replaces the pending request. A later window that requests no change cancels an earlier up or down request that has not yet been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample valid |
| smp_mag | input | MAG_W | Sample magnitude |
| smp_sat | input | 1 | Sample saturated flag |
| row_stb | input | 1 | Row boundary strobe |
| recov_busy | input | 1 | Overload recovery in progress |
| lvl_lo | input | MAG_W | Mean below this level requests more gain |
| lvl_hi | input | MAG_W | Mean above this level requests less gain |
| sat_limit | input | WIN_LOG2+1 | Largest tolerated saturated count per window |
| holdoff_rows | input | HOLD_W | Rows frozen after each switch |
| gain_idx | output | GAIN_W | Current gain state |
| gain_switch | output | 1 | One-cycle pulse on a gain change |
| row_tag | output | GAIN_W | Gain state tag of the current row |
| row_tag_vld | output | 1 | Row tag valid pulse |

## Verification
Windows are built from magnitude ramps whose means land below, on, between and above the two levels, which separates the hysteresis band from the strict-inequality edges. Saturated counts just at and just over the limit show that the saturation path overrides a low mean. Requests are also sent at the index extremes, under an active hold-off and during recovery, which tells bounds, freezing and forced fallback apart. A partial window and a cancelling window confirm that only complete windows count and that the newest one wins. A long mixed sweep compares every row boundary against an arithmetic model of the rules.

// File: rtl/gr_pkg.sv
package gr_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_UP   = 2'd1,
    REQ_DOWN = 2'd2
  } gr_req_e;
endpackage

// File: rtl/gr_window.sv
module gr_window #(
  parameter int MAG_W    = 12,
  parameter int WIN_LOG2 = 3,
  localparam int SUM_W   = MAG_W + WIN_LOG2,
  localparam int CNT_W   = WIN_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [MAG_W-1:0] smp_mag,
  input  logic             smp_sat,
  output logic             win_vld,
  output logic [MAG_W-1:0] win_mean,
  output logic [CNT_W-1:0] win_sat
);
  // mean of the window: drop the low WIN_LOG2 bits of the sum
  function automatic logic [MAG_W-1:0] mean_of(input logic [SUM_W-1:0] s);
    return s[SUM_W-1:WIN_LOG2];
  endfunction

  logic [SUM_W-1:0]    sum_q, sum_nxt;
  logic [CNT_W-1:0]    sat_q, sat_nxt;
  logic [WIN_LOG2-1:0] idx_q;
  logic                last_smp;

  always_comb begin
    sum_nxt  = sum_q + SUM_W'(smp_mag);
    sat_nxt  = sat_q + CNT_W'(smp_sat);
    last_smp = smp_vld && (idx_q == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q    <= '0;
      sat_q    <= '0;
      idx_q    <= '0;
      win_vld  <= 1'b0;
      win_mean <= '0;
      win_sat  <= '0;
    end else begin
      win_vld <= last_smp;
      if (smp_vld) begin
        idx_q <= idx_q + 1'b1;
        if (last_smp) begin
          win_mean <= mean_of(sum_nxt);
          win_sat  <= sat_nxt;
          sum_q    <= '0;
          sat_q    <= '0;
        end else begin
          sum_q <= sum_nxt;
          sat_q <= sat_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/gr_holdoff.sv
module gr_holdoff #(
  parameter int HOLD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb,
  input  logic              reload,
  input  logic [HOLD_W-1:0] load_val,
  output logic              hold_active
);
  logic [HOLD_W-1:0] cnt_q;

  assign hold_active = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (reload) begin
      cnt_q <= load_val;
    end else if (row_stb && hold_active) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/gain_range_ctrl.sv
module gain_range_ctrl #(
  parameter int MAG_W     = 12,
  parameter int WIN_LOG2  = 3,
  parameter int GAIN_W    = 2,
  parameter int HOLD_W    = 6,
  parameter int SAFE_GAIN = 0,
  localparam int CNT_W    = WIN_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [MAG_W-1:0]  smp_mag,
  input  logic              smp_sat,
  input  logic              row_stb,
  input  logic              recov_busy,
  input  logic [MAG_W-1:0]  lvl_lo,
  input  logic [MAG_W-1:0]  lvl_hi,
  input  logic [CNT_W-1:0]  sat_limit,
  input  logic [HOLD_W-1:0] holdoff_rows,
  output logic [GAIN_W-1:0] gain_idx,
  output logic              gain_switch,
  output logic [GAIN_W-1:0] row_tag,
  output logic              row_tag_vld
);
  import gr_pkg::*;

  localparam logic [GAIN_W-1:0] G_MAX  = '1;
  localparam logic [GAIN_W-1:0] G_MIN  = '0;
  localparam logic [GAIN_W-1:0] G_SAFE = GAIN_W'(SAFE_GAIN);

  // window statistics -> one request
  function automatic gr_req_e classify(input logic [MAG_W-1:0] mean,
                                       input logic [CNT_W-1:0] satc,
                                       input logic [MAG_W-1:0] lo,
                                       input logic [MAG_W-1:0] hi,
                                       input logic [CNT_W-1:0] lim);
    if (satc > lim)    return REQ_DOWN;
    else if (mean > hi) return REQ_DOWN;
    else if (mean < lo) return REQ_UP;
    else                return REQ_NONE;
  endfunction

  logic             win_vld;
  logic [MAG_W-1:0] win_mean;
  logic [CNT_W-1:0] win_sat;
  logic             hold_active;
  gr_req_e          pend_q;

  // named internal events
  logic             consume_evt;
  logic             force_evt;
  logic             step_up_evt;
  logic             step_dn_evt;
  logic             switch_evt;
  logic [GAIN_W-1:0] gain_nxt;

  gr_window #(.MAG_W(MAG_W), .WIN_LOG2(WIN_LOG2)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .smp_mag  (smp_mag),
    .smp_sat  (smp_sat),
    .win_vld  (win_vld),
    .win_mean (win_mean),
    .win_sat  (win_sat)
  );

  gr_holdoff #(.HOLD_W(HOLD_W)) u_holdoff (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_stb     (row_stb),
    .reload      (switch_evt),
    .load_val    (holdoff_rows),
    .hold_active (hold_active)
  );

  always_comb begin
    consume_evt = row_stb && !hold_active && !recov_busy;
    force_evt   = row_stb && recov_busy && (gain_idx != G_SAFE);
    step_up_evt = consume_evt && (pend_q == REQ_UP) && (gain_idx != G_MAX);
    step_dn_evt = consume_evt && (pend_q == REQ_DOWN) && (gain_idx != G_MIN);
    switch_evt  = force_evt || step_up_evt || step_dn_evt;
    gain_nxt    = gain_idx;
    if (force_evt)        gain_nxt = G_SAFE;
    else if (step_up_evt) gain_nxt = gain_idx + 1'b1;
    else if (step_dn_evt) gain_nxt = gain_idx - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= REQ_NONE;
    end else if (recov_busy) begin
      pend_q <= REQ_NONE;
    end else if (win_vld) begin
      pend_q <= classify(win_mean, win_sat, lvl_lo, lvl_hi, sat_limit);
    end else if (consume_evt) begin
      pend_q <= REQ_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_idx    <= G_SAFE;
      gain_switch <= 1'b0;
      row_tag     <= G_SAFE;
      row_tag_vld <= 1'b0;
    end else begin
      gain_idx    <= gain_nxt;
      gain_switch <= switch_evt;
      row_tag_vld <= row_stb;
      if (row_stb) row_tag <= gain_nxt;
    end
  end
endmodule

// File: rtl/gain_range_ctrl_chk.sv
module gain_range_ctrl_chk #(
  parameter int GAIN_W    = 2,
  parameter int SAFE_GAIN = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_stb,
  input logic              recov_busy,
  input logic              hold_active,
  input logic [GAIN_W-1:0] gain_idx,
  input logic              gain_switch,
  input logic [GAIN_W-1:0] row_tag,
  input logic              row_tag_vld
);
  localparam logic [GAIN_W-1:0] G_SAFE = GAIN_W'(SAFE_GAIN);

  assert_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_idx != $past(gain_idx)) |->
      (gain_idx == G_SAFE ||
       {1'b0, gain_idx} == {1'b0, $past(gain_idx)} + 1'b1 ||
       {1'b0, $past(gain_idx)} == {1'b0, gain_idx} + 1'b1));

  assert_row_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_idx != $past(gain_idx)) |-> $past(row_stb));

  assert_pulse_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_switch |-> (gain_idx != $past(gain_idx)));

  assert_no_silent_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_switch |-> $stable(gain_idx));

  assert_holdoff_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb && hold_active && !recov_busy) |=> !gain_switch);

  assert_force_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb && recov_busy) |=> (gain_idx == G_SAFE));

  assert_tag_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_tag_vld |-> (row_tag == gain_idx && $past(row_stb)));
endmodule

bind gain_range_ctrl gain_range_ctrl_chk #(.GAIN_W(GAIN_W), .SAFE_GAIN(SAFE_GAIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .row_stb     (row_stb),
  .recov_busy  (recov_busy),
  .hold_active (hold_active),
  .gain_idx    (gain_idx),
  .gain_switch (gain_switch),
  .row_tag     (row_tag),
  .row_tag_vld (row_tag_vld)
);

// File: tb/gain_range_ctrl_tb.sv
module gain_range_ctrl_tb;
  localparam int MAG_W = 12, WIN_LOG2 = 3, GAIN_W = 2, HOLD_W = 6;
  localparam int CNT_W = WIN_LOG2 + 1, WIN = 1 << WIN_LOG2, GMAX = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_vld = 1'b0;
  logic [MAG_W-1:0]  smp_mag = '0;
  logic              smp_sat = 1'b0;
  logic              row_stb = 1'b0;
  logic              recov_busy = 1'b0;
  logic [MAG_W-1:0]  lvl_lo = 12'd100;
  logic [MAG_W-1:0]  lvl_hi = 12'd200;
  logic [CNT_W-1:0]  sat_limit = 4'd2;
  logic [HOLD_W-1:0] holdoff_rows = '0;
  logic [GAIN_W-1:0] gain_idx;
  logic              gain_switch;
  logic [GAIN_W-1:0] row_tag;
  logic              row_tag_vld;

  always #2 clk = ~clk;

  gain_range_ctrl #(.MAG_W(MAG_W), .WIN_LOG2(WIN_LOG2), .GAIN_W(GAIN_W),
                    .HOLD_W(HOLD_W), .SAFE_GAIN(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_mag(smp_mag),
    .smp_sat(smp_sat), .row_stb(row_stb), .recov_busy(recov_busy),
    .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .sat_limit(sat_limit),
    .holdoff_rows(holdoff_rows), .gain_idx(gain_idx), .gain_switch(gain_switch),
    .row_tag(row_tag), .row_tag_vld(row_tag_vld)
  );

  int checks = 0, errors = 0;
  // bench model: pend 0 none, 1 up, 2 down
  int m_gain = 0, m_hold = 0, m_pend = 0;
  int acc_sum = 0, acc_cnt = 0, acc_sat = 0, last_sat = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_samples(input int base, input int count, input int nsat);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      smp_vld = 1'b1;
      smp_mag = MAG_W'(base + i);
      smp_sat = (i < nsat);
      acc_sum += base + i;
      acc_sat += (i < nsat) ? 1 : 0;
      acc_cnt++;
      if (acc_cnt == WIN) begin
        int mean = acc_sum / WIN;
        last_sat = acc_sat;
        if (recov_busy)                   m_pend = 0;
        else if (acc_sat > int'(sat_limit)) m_pend = 2;
        else if (mean > int'(lvl_hi))     m_pend = 2;
        else if (mean < int'(lvl_lo))     m_pend = 1;
        else                              m_pend = 0;
        acc_sum = 0; acc_cnt = 0; acc_sat = 0;
      end
    end
    @(negedge clk);
    smp_vld = 1'b0;
    smp_sat = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_busy(input logic b);
    @(negedge clk);
    recov_busy = b;
    if (b) m_pend = 0;
    @(negedge clk);
  endtask

  task automatic strobe(input string req);
    int sw = 0;
    if (recov_busy) begin
      if (m_gain != 0) begin m_gain = 0; sw = 1; end
      m_pend = 0;
    end else if (m_hold == 0) begin
      if (m_pend == 1 && m_gain < GMAX) begin m_gain++; sw = 1; end
      else if (m_pend == 2 && m_gain > 0) begin m_gain--; sw = 1; end
      m_pend = 0;
    end
    if (sw == 1) m_hold = int'(holdoff_rows);
    else if (m_hold > 0) m_hold--;
    @(negedge clk);
    row_stb = 1'b1;
    @(negedge clk);
    row_stb = 1'b0;
    chk(req, "gain_switch", int'(gain_switch), sw);
    chk(req, "gain_idx", int'(gain_idx), m_gain);
    chk("R9", "row_tag", int'(row_tag), m_gain);
    chk("R9", "row_tag_vld", int'(row_tag_vld), 1);
    @(negedge clk);
    chk("R6", "pulse width", int'(gain_switch), 0);
    chk("R9", "tag_vld width", int'(row_tag_vld), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "gain_idx", int'(gain_idx), 0);
    chk("R1", "gain_switch", int'(gain_switch), 0);
    chk("R1", "row_tag", int'(row_tag), 0);
    chk("R1", "row_tag_vld", int'(row_tag_vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 low mean steps up
    drive_samples(40, 8, 0);   strobe("R3");
    // R2 partial window has no effect, completing it does
    drive_samples(4000, 7, 0); strobe("R2");
    drive_samples(4000, 1, 0); strobe("R2");
    // R3 band and strict edges
    drive_samples(147, 8, 0);  strobe("R3");
    drive_samples(197, 8, 0);  strobe("R3");
    drive_samples(97, 8, 0);   strobe("R3");
    // R4 saturation override at and over the limit
    drive_samples(40, 8, 0);   strobe("R3");
    drive_samples(40, 8, 3);   strobe("R4");
    drive_samples(147, 8, 2);  strobe("R4");
    // R5 bounds
    drive_samples(300, 8, 0);  strobe("R5");
    for (int k = 0; k < 3; k++) begin
      drive_samples(40, 8, 0); strobe("R5");
    end
    drive_samples(40, 8, 0);   strobe("R5");
    // R10 newer window cancels
    drive_samples(300, 8, 0);
    drive_samples(147, 8, 0);  strobe("R10");
    // R7 hold-off
    holdoff_rows = 6'd2;
    drive_samples(300, 8, 0);  strobe("R7");
    drive_samples(300, 8, 0);  strobe("R7");
    strobe("R7");
    strobe("R7");
    // R8 recovery forces safe state despite hold-off
    drive_samples(300, 8, 0);  strobe("R7");
    set_busy(1'b1);
    drive_samples(40, 8, 0);   strobe("R8");
    strobe("R8");
    set_busy(1'b0);
    strobe("R8");
    // R6 no change without a row strobe
    holdoff_rows = 6'd0;
    repeat (3) strobe("R7");
    drive_samples(40, 8, 0);
    repeat (5) @(negedge clk);
    chk("R6", "gain held without strobe", int'(gain_idx), m_gain);
    strobe("R6");

    // mixed sweep against the model
    for (int it = 0; it < 80; it++) begin
      string tag;
      int base = (it * 37) % 300;
      int nsat = (it % 5 == 0) ? 3 : it % 3;
      holdoff_rows = HOLD_W'(it % 3);
      if (it % 11 == 7) set_busy(1'b1);
      drive_samples(base, 8, nsat);
      if (recov_busy)                       tag = "R8";
      else if (m_hold != 0)                 tag = "R7";
      else if (last_sat > int'(sat_limit))  tag = "R4";
      else if ((m_pend == 1 && m_gain == GMAX) || (m_pend == 2 && m_gain == 0)) tag = "R5";
      else                                  tag = "R3";
      strobe(tag);
      if (recov_busy) set_busy(1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule